// File: doc/BRIEF.md
# Binary32 to Binary16 Narrowing Converter

This unit narrows one IEEE 754 single-precision operand to a 16-bit half-precision value. It merges that value into either the upper or the lower half of a 32-bit destination word, and the other half of the word passes through unchanged. A conversion is requested with a one-cycle strobe. The merged word appears one clock later, and four status flags gather exceptions across conversions until reset.

The datapath has one shared right-shift. It serves both normal results and results that need gradual underflow, so a tiny value is rounded only once, from exact guard and sticky bits. The result can be encoded in standard half precision. It can also be encoded in an alternative half format that has no infinities or NaNs, where the all-ones exponent is an ordinary binade and out-of-range values saturate. Other controls select the rounding direction, substitution of the default NaN, flushing of denormal binary32 inputs, and reporting of exact underflow.

Top module: `f32_to_f16_pack`

## Requirements
- R1: A high `in_valid` makes `out_valid` high on the next clock and loads `dest_out` with the merged word. When `in_valid` is low, `out_valid` goes low the cycle after, and `dest_out` holds its value whatever the other inputs do.
- R2: The 16-bit result is laid out as sign at bit 15, exponent at bits 14:10 and fraction at bits 9:0. With `hi_sel`=1 it replaces `dest_out[31:16]`. With `hi_sel`=0 it replaces `dest_out[15:0]`. The other half is a copy of `dest_in`.
- R3: Finite inputs are rebiased by subtracting 112 from the exponent. Values that fit exactly convert with no flag raised.
- R4: `rmode` encodes the rounding direction: 0 is nearest-even, 1 is toward +infinity, 2 is toward -infinity and 3 is toward zero. Nearest-even increments when the guard bit is set and either the sticky bit or the kept LSB is set. The directed modes increment only when dropped bits are nonzero and the sign matches the direction.
- R5: A rounding carry out of the fraction clears the fraction and raises the exponent by one. This includes a subnormal result that rounds up to the smallest normal value.
- R6: If the biased binary32 exponent is 112 or less, the result is a subnormal built by shifting the significand right with exact guard and sticky tracking. The underflow flag is raised for such a result when it is inexact or when `ufl_trap_en` is set.
- R7: In standard mode, a rounded exponent of 31 or more raises overflow and inexact. The result is infinity for nearest-even, for toward +infinity on a positive value and for toward -infinity on a negative value. In every other case the result is the signed largest finite value, exponent 30 with fraction 0x3FF.
- R8: In the alternative format (`alt_fmt`=1), exponent 31 is a normal binade. A rounded exponent of 32 or more saturates to exponent 31 with fraction 0x3FF and raises invalid, not inexact, and never overflow.
- R9: A binary32 NaN whose fraction bit 22 is clear is signalling and raises invalid. In standard mode without `dflt_nan`, a NaN keeps its sign and the top 10 fraction bits, with half fraction bit 9 forced to 1.
- R10: In standard mode with `dflt_nan`=1, every NaN becomes 0x7E00.
- R11: In the alternative format, a NaN becomes a zero of the same sign, and an infinity becomes exponent 31 with fraction 0x3FF. Both raise invalid. In standard mode an infinity converts to an infinity with no flag.
- R12: Zeros keep their sign. With `flush_den`=1, a denormal binary32 input becomes a zero of the same sign and raises no flag. With `flush_den`=0, it is rounded like any tiny value.
- R13: Inexact is raised whenever dropped bits are nonzero, except in the saturation case of R8.
- R14: The four flags are sticky and can be cleared only by reset. Reset clears `out_valid`, `dest_out` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request strobe |
| op_in | input | 32 | Binary32 operand |
| dest_in | input | 32 | Destination word to merge into |
| hi_sel | input | 1 | 1: write upper half, 0: write lower half |
| rmode | input | 2 | Rounding direction (see R4) |
| alt_fmt | input | 1 | Alternative half format with no infinities or NaNs |
| dflt_nan | input | 1 | Substitute the default NaN |
| flush_den | input | 1 | Flush denormal binary32 inputs to zero |
| ufl_trap_en | input | 1 | Report underflow even when the result is exact |
| out_valid | output | 1 | Merged word updated this cycle |
| dest_out | output | 32 | Merged destination word |
| flag_inv | output | 1 | Sticky invalid-operation flag |
| flag_ufl | output | 1 | Sticky underflow flag |
| flag_ofl | output | 1 | Sticky overflow flag |
| flag_inx | output | 1 | Sticky inexact flag |

## Verification
The assertions check on every cycle:
- the one-cycle strobe-to-result timing;
- the preservation of the unselected half;
- the stickiness of the flags, and that overflow always comes with inexact;
- that the alternative format never reports overflow;
- the default-NaN substitution.

Only the directed scenarios can show the arithmetic itself: the tie-breaking of each rounding direction, carries into the exponent and into the smallest normal, the exact-versus-inexact underflow rule, the choice of overflow result by rounding direction, and NaN payload handling. They compare merged words and flags against values worked out by hand for each boundary operand.

// File: rtl/f32_to_f16_pack.sv
module f32_to_f16_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_in,
  input  logic [31:0] dest_in,
  input  logic        hi_sel,
  input  logic [1:0]  rmode,
  input  logic        alt_fmt,
  input  logic        dflt_nan,
  input  logic        flush_den,
  input  logic        ufl_trap_en,
  output logic        out_valid,
  output logic [31:0] dest_out,
  output logic        flag_inv,
  output logic        flag_ufl,
  output logic        flag_ofl,
  output logic        flag_inx
);
  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_UP   = 2'd1;
  localparam logic [1:0] RM_DOWN = 2'd2;
  localparam int         BIAS_D  = 112;
  localparam int         SH_MAX  = 40;

  logic       sgn;
  logic [7:0] ex;
  logic [22:0] fr;
  assign sgn = op_in[31];
  assign ex  = op_in[30:23];
  assign fr  = op_in[22:0];

  logic is_nan, is_inf, is_zero, is_den;
  assign is_nan  = (&ex) && (|fr);
  assign is_inf  = (&ex) && !(|fr);
  assign is_zero = (ex == 8'd0) && !(|fr);
  assign is_den  = (ex == 8'd0) && (|fr);

  // effective exponent: binary32 denormals share the scale of exponent 1
  logic [7:0] ee;
  logic       tiny;
  logic [7:0] sh_raw;
  logic [5:0] sh;
  assign ee     = (ex == 8'd0) ? 8'd1 : ex;
  assign tiny   = ee <= 8'(BIAS_D);
  assign sh_raw = 8'(BIAS_D + 1) - ee;
  assign sh     = !tiny ? 6'd0 : (sh_raw > 8'(SH_MAX)) ? 6'(SH_MAX) : sh_raw[5:0];

  logic [63:0] wide;
  logic [10:0] kept;
  logic        grd, stk, lost;
  assign wide = {ex != 8'd0, fr, 40'd0} >> sh;
  assign kept = wide[63:53];
  assign grd  = wide[52];
  assign stk  = |wide[51:0];
  assign lost = grd | stk;

  logic inc;
  always_comb begin
    case (rmode)
      RM_NEAR: inc = grd & (stk | kept[0]);
      RM_UP:   inc = !sgn & lost;
      RM_DOWN: inc = sgn & lost;
      default: inc = 1'b0;
    endcase
  end

  // exponent base excludes the hidden bit, which lives in kept[10]
  logic [8:0]  base;
  logic [19:0] packed_r;
  logic [9:0]  exp_r;
  logic [9:0]  frac_r;
  assign base     = tiny ? 9'd0 : 9'(ee - 8'(BIAS_D + 1));
  assign packed_r = {1'b0, base, 10'd0} + 20'(kept) + 20'(inc);
  assign exp_r    = packed_r[19:10];
  assign frac_r   = packed_r[9:0];

  logic to_inf;
  assign to_inf = (rmode == RM_NEAR) || (rmode == RM_UP && !sgn) || (rmode == RM_DOWN && sgn);

  logic [15:0] res;
  logic        f_inv, f_ufl, f_ofl, f_inx;
  always_comb begin
    res   = {sgn, 15'd0};
    f_inv = 1'b0;
    f_ufl = 1'b0;
    f_ofl = 1'b0;
    f_inx = 1'b0;
    if (is_nan) begin
      f_inv = !fr[22];
      if (alt_fmt) begin
        res   = {sgn, 15'd0};
        f_inv = 1'b1;
      end else if (dflt_nan) begin
        res = 16'h7E00;
      end else begin
        res = {sgn, 5'h1F, 1'b1, fr[21:13]};
      end
    end else if (is_inf) begin
      if (alt_fmt) begin
        res   = {sgn, 5'h1F, 10'h3FF};
        f_inv = 1'b1;
      end else begin
        res = {sgn, 5'h1F, 10'h000};
      end
    end else if (is_zero || (is_den && flush_den)) begin
      res = {sgn, 15'd0};
    end else begin
      f_inx = lost;
      f_ufl = tiny && (lost || ufl_trap_en);
      res   = {sgn, exp_r[4:0], frac_r};
      if (alt_fmt) begin
        if (exp_r >= 10'd32) begin
          res   = {sgn, 5'h1F, 10'h3FF};
          f_inv = 1'b1;
          f_inx = 1'b0;
        end
      end else if (exp_r >= 10'd31) begin
        res   = to_inf ? {sgn, 5'h1F, 10'h000} : {sgn, 5'h1E, 10'h3FF};
        f_ofl = 1'b1;
        f_inx = 1'b1;
      end
    end
  end

  logic [31:0] merged;
  assign merged = hi_sel ? {res, dest_in[15:0]} : {dest_in[31:16], res};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dest_out  <= 32'd0;
      flag_inv  <= 1'b0;
      flag_ufl  <= 1'b0;
      flag_ofl  <= 1'b0;
      flag_inx  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dest_out <= merged;
        flag_inv <= flag_inv | f_inv;
        flag_ufl <= flag_ufl | f_ufl;
        flag_ofl <= flag_ofl | f_ofl;
        flag_inx <= flag_inx | f_inx;
      end
    end
  end

  assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dest_out)));
  assert_keep_low_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hi_sel) |=> dest_out[15:0] == $past(dest_in[15:0]));
  assert_keep_high_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hi_sel) |=> dest_out[31:16] == $past(dest_in[31:16]));
  assert_ofl_has_inx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ofl |-> flag_inx);
  assert_alt_no_ofl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alt_fmt && !flag_ofl) |=> !flag_ofl);
  assert_default_nan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !alt_fmt && dflt_nan && (&op_in[30:23]) && (|op_in[22:0])) |=>
      (($past(hi_sel) ? dest_out[31:16] : dest_out[15:0]) == 16'h7E00));
  assert_sticky_inv_R14: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |=> flag_inv);
  assert_sticky_ufl_R14: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ufl |=> flag_ufl);
  assert_sticky_inx_R14: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inx |=> flag_inx);
endmodule

// File: tb/f32_to_f16_pack_tb.sv
module f32_to_f16_pack_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_in = '0;
  logic [31:0] dest_in = '0;
  logic        hi_sel = 1'b0;
  logic [1:0]  rmode = 2'd0;
  logic        alt_fmt = 1'b0;
  logic        dflt_nan = 1'b0;
  logic        flush_den = 1'b0;
  logic        ufl_trap_en = 1'b0;
  logic        out_valid;
  logic [31:0] dest_out;
  logic        flag_inv, flag_ufl, flag_ofl, flag_inx;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f32_to_f16_pack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in), .dest_in(dest_in),
    .hi_sel(hi_sel), .rmode(rmode), .alt_fmt(alt_fmt), .dflt_nan(dflt_nan),
    .flush_den(flush_den), .ufl_trap_en(ufl_trap_en), .out_valid(out_valid),
    .dest_out(dest_out), .flag_inv(flag_inv), .flag_ufl(flag_ufl),
    .flag_ofl(flag_ofl), .flag_inx(flag_inx)
  );

  // flag vector order: {invalid, underflow, overflow, inexact}
  function automatic logic [3:0] flags();
    return {flag_inv, flag_ufl, flag_ofl, flag_inx};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mode bits: {alt_fmt, dflt_nan, flush_den, ufl_trap_en}
  task automatic conv(input logic [31:0] op, input logic [31:0] dst, input logic hi,
                      input logic [1:0] rm, input logic [3:0] mode);
    @(negedge clk);
    op_in = op; dest_in = dst; hi_sel = hi; rmode = rm;
    {alt_fmt, dflt_nan, flush_den, ufl_trap_en} = mode;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // fresh reset, convert into low half of a zero word, check result and flags
  task automatic one(input string req, input logic [31:0] op, input logic [1:0] rm,
                     input logic [3:0] mode, input logic [15:0] exp_h, input logic [3:0] exp_f);
    do_reset();
    conv(op, 32'h0, 1'b0, rm, mode);
    chk(req, "result", {16'h0, dest_out[15:0]}, {16'h0, exp_h});
    chk(req, "flags", {28'h0, flags()}, {28'h0, exp_f});
  endtask

  task automatic t_reset_and_timing();
    do_reset();
    chk("R14", "reset word", dest_out, 32'h0);
    chk("R14", "reset flags+valid", {27'h0, out_valid, flags()}, 32'h0);
    conv(32'h3F800000, 32'hAAAA5555, 1'b0, 2'd0, 4'b0000);
    chk("R1", "valid after strobe", {31'h0, out_valid}, 32'h1);
    chk("R3", "1.0 low merge", dest_out, 32'hAAAA3C00);
    @(negedge clk);
    op_in = 32'hC0000000; dest_in = 32'h0;
    @(negedge clk);
    chk("R1", "hold without strobe", dest_out, 32'hAAAA3C00);
    chk("R1", "valid drops", {31'h0, out_valid}, 32'h0);
  endtask

  task automatic t_merge();
    do_reset();
    conv(32'hC0000000, 32'h12345678, 1'b1, 2'd0, 4'b0000);
    chk("R2", "-2.0 high merge", dest_out, 32'hC0005678);
    chk("R3", "exact no flags", {28'h0, flags()}, 32'h0);
    one("R3", 32'h477FE000, 2'd0, 4'b0000, 16'h7BFF, 4'b0000);
  endtask

  task automatic t_round();
    one("R4", 32'h3F801000, 2'd0, 4'b0000, 16'h3C00, 4'b0001);
    one("R4", 32'h3F803000, 2'd0, 4'b0000, 16'h3C02, 4'b0001);
    one("R4", 32'h3F801001, 2'd0, 4'b0000, 16'h3C01, 4'b0001);
    one("R4", 32'h3F801000, 2'd1, 4'b0000, 16'h3C01, 4'b0001);
    one("R4", 32'h3F801000, 2'd2, 4'b0000, 16'h3C00, 4'b0001);
    one("R4", 32'h3F801000, 2'd3, 4'b0000, 16'h3C00, 4'b0001);
    one("R4", 32'hBF801000, 2'd1, 4'b0000, 16'hBC00, 4'b0001);
    one("R4", 32'hBF801000, 2'd2, 4'b0000, 16'hBC01, 4'b0001);
    one("R5", 32'h3FFFF000, 2'd0, 4'b0000, 16'h4000, 4'b0001);
  endtask

  task automatic t_subnormal();
    one("R6", 32'h33800000, 2'd0, 4'b0000, 16'h0001, 4'b0000);
    one("R6", 32'h33800000, 2'd0, 4'b0001, 16'h0001, 4'b0100);
    one("R6", 32'h33000000, 2'd0, 4'b0000, 16'h0000, 4'b0101);
    one("R6", 32'h33000000, 2'd1, 4'b0000, 16'h0001, 4'b0101);
    one("R6", 32'h33400000, 2'd0, 4'b0000, 16'h0001, 4'b0101);
    one("R5", 32'h387FF000, 2'd0, 4'b0000, 16'h0400, 4'b0101);
  endtask

  task automatic t_overflow();
    one("R7", 32'h48000000, 2'd0, 4'b0000, 16'h7C00, 4'b0011);
    one("R7", 32'h48000000, 2'd3, 4'b0000, 16'h7BFF, 4'b0011);
    one("R7", 32'h48000000, 2'd1, 4'b0000, 16'h7C00, 4'b0011);
    one("R7", 32'h48000000, 2'd2, 4'b0000, 16'h7BFF, 4'b0011);
    one("R7", 32'hC8000000, 2'd2, 4'b0000, 16'hFC00, 4'b0011);
    one("R7", 32'hC8000000, 2'd1, 4'b0000, 16'hFBFF, 4'b0011);
    one("R7", 32'h477FF000, 2'd0, 4'b0000, 16'h7C00, 4'b0011);
    one("R13", 32'h477FF000, 2'd3, 4'b0000, 16'h7BFF, 4'b0001);
  endtask

  task automatic t_alt();
    one("R8", 32'h47800000, 2'd0, 4'b1000, 16'h7C00, 4'b0000);
    one("R8", 32'h48000000, 2'd0, 4'b1000, 16'h7FFF, 4'b1000);
    one("R11", 32'hFFC00000, 2'd0, 4'b1000, 16'h8000, 4'b1000);
    one("R11", 32'h7F800000, 2'd0, 4'b1000, 16'h7FFF, 4'b1000);
  endtask

  task automatic t_nan();
    one("R9", 32'h7FC00000, 2'd0, 4'b0000, 16'h7E00, 4'b0000);
    one("R9", 32'h7F800001, 2'd0, 4'b0000, 16'h7E00, 4'b1000);
    one("R9", 32'hFFA00000, 2'd0, 4'b0000, 16'hFF00, 4'b1000);
    one("R10", 32'hFFA00000, 2'd0, 4'b0100, 16'h7E00, 4'b1000);
    one("R10", 32'hFFE00000, 2'd0, 4'b0100, 16'h7E00, 4'b0000);
    one("R11", 32'hFF800000, 2'd0, 4'b0000, 16'hFC00, 4'b0000);
  endtask

  task automatic t_zero();
    one("R12", 32'h80000000, 2'd0, 4'b0000, 16'h8000, 4'b0000);
    one("R12", 32'h80000001, 2'd1, 4'b0010, 16'h8000, 4'b0000);
    one("R12", 32'h00000001, 2'd0, 4'b0000, 16'h0000, 4'b0101);
    one("R12", 32'h00000001, 2'd1, 4'b0000, 16'h0001, 4'b0101);
  endtask

  task automatic t_sticky();
    do_reset();
    conv(32'h48000000, 32'h0, 1'b0, 2'd0, 4'b0000);
    conv(32'h3F800000, 32'h0, 1'b0, 2'd0, 4'b0000);
    chk("R14", "later exact result", dest_out, 32'h00003C00);
    chk("R14", "flags kept", {28'h0, flags()}, 32'h3);
    do_reset();
    chk("R14", "reset clears flags", {28'h0, flags()}, 32'h0);
  endtask

  initial begin
    t_reset_and_timing();
    t_merge();
    t_round();
    t_subnormal();
    t_overflow();
    t_alt();
    t_nan();
    t_zero();
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule